// File: doc/BRIEF.md
# FIFO Burst Request Handshake Controller

This block sits beside an on-chip FIFO and asks an external DMA engine to move data in fixed bursts of 16 words. In the fill direction the DMA engine writes into the FIFO. In the drain direction it reads out of the FIFO. The controller raises a request line when the FIFO can absorb or supply a whole burst. It then watches the acknowledge and the two data strobes and emits one push or pop pulse per accepted word. After the sixteenth word it waits a short fixed gap before it may ask again.

A 4-bit field sets the shape of the request. Values 1 to 15 give a pulse of that many core-clock cycles. Zero gives a level request that is held until the first accepted strobe arrives. The acknowledge and both strobes come from outside the clock domain, so they pass through a synchronizer before their rising edges are detected.

A separate single-word mode replaces bursts with a service-request flag that follows FIFO occupancy. In this mode each read strobe pops one word.

The state machine has five states:
- `REQ_IDLE` moves to `REQ_PULSE` when a burst is allowed and the field is nonzero. It moves to `REQ_LEVEL` when a burst is allowed and the field is zero.
- `REQ_PULSE` moves to `REQ_XFER` when the pulse timer expires.
- `REQ_LEVEL` moves to `REQ_XFER` on the first accepted access.
- `REQ_PULSE`, `REQ_LEVEL` and `REQ_XFER` all move to `REQ_GAP` on the sixteenth accepted access.
- `REQ_GAP` returns to `REQ_IDLE` when the gap timer expires.

Top module: `fifo_dma_req_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `dreq`, `fifo_push`, `fifo_pop` and `svc_req` all low, and the access count is zero. A burst after reset therefore needs a full 16 accesses.
- R2: When `cfg_pulse_len` holds N in the range 1 to 15, each request holds `dreq` high for exactly N consecutive clock cycles.
- R3: When `cfg_pulse_len` is 0, `dreq` stays high with no time limit until the first acknowledged strobe of the burst direction. It then falls within 2 to 4 clock cycles after that strobe rises.
- R4: A request starts only from idle, and only when a burst is allowed. With `dir_rd`=0 (fill), a burst is allowed when `fifo_free` is at least 16. With `dir_rd`=1 (drain), a burst is allowed when `fifo_used` is at least 16. When no burst is allowed, `dreq` stays low.
- R5: During a request or burst, each rising edge of the strobe for the latched direction, taken with acknowledge high, gives exactly one single-cycle pulse. That pulse is `fifo_push` when `wr_strobe` is the burst strobe, and `fifo_pop` when `rd_strobe` is. A strobe held high counts once. The strobe of the other direction gives no pulse.
- R6: A strobe edge that is synchronized while `dma_ack` is low gives no push or pop pulse. It does not advance the burst and does not end a level request.
- R7: A burst is exactly 16 accesses, and `dreq` does not rise again before the sixteenth. If a burst is still allowed, the next `dreq` rise comes exactly GAP_CYC+2 cycles (5 with defaults) after the cycle that carries the sixteenth push or pop.
- R8: A change of `dir_rd` after a request has started has no effect on the burst in flight. The direction latched at request start decides which strobe counts and which pulse is given.
- R9: With `single_mode` high, `dreq` is never raised. In this mode `svc_req` equals (`fifo_used` != 0) with one cycle of delay, and each synchronized `rd_strobe` rising edge in idle gives one `fifo_pop` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pulse_len | input | 4 | Request pulse length in cycles; 0 selects level request |
| dir_rd | input | 1 | 0 = fill bursts (DMA writes), 1 = drain bursts (DMA reads) |
| single_mode | input | 1 | Selects single-word service mode instead of bursts |
| fifo_free | input | 8 | Free words in the FIFO |
| fifo_used | input | 8 | Occupied words in the FIFO |
| dma_ack | input | 1 | DMA acknowledge, asynchronous, active high |
| wr_strobe | input | 1 | DMA write strobe, asynchronous, active high |
| rd_strobe | input | 1 | DMA read strobe, asynchronous, active high |
| dreq | output | 1 | DMA request |
| fifo_push | output | 1 | One-cycle pulse per accepted write word |
| fifo_pop | output | 1 | One-cycle pulse per accepted read word |
| svc_req | output | 1 | Single-mode service request, FIFO not empty |

## Verification
The pulse request is tried with fixed and random lengths from 1 to 15. It is told apart from the level request by holding a level request for 30 cycles and timing its fall after one strobe. The fill and drain bursts are interleaved with unacknowledged strobes and with acknowledged strobes of the wrong direction. Only correctly qualified edges must be counted, so any loss of the acknowledge gating or the direction gating changes the push and pop totals. A burst is stopped one access short to show that no early re-request occurs, and the gap to the next request is timed to the cycle. A mid-burst direction flip and a FIFO that is too full or too empty separate the latched direction and the idle-only gating from a design that reacts live.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
    typedef enum logic [2:0] {
        REQ_IDLE,
        REQ_PULSE,
        REQ_LEVEL,
        REQ_XFER,
        REQ_GAP
    } req_state_e;
endpackage

// File: rtl/fdr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module fdr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], async_in};
        end
    end

    assign sync_out = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/fdr_burst_cnt.sv
// Counts accepted accesses and flags the final access of a burst.
module fdr_burst_cnt #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic last_hit
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] count_q;

    assign last_hit = inc && (count_q == CW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= last_hit ? '0 : count_q + 1'b1;
        end
    end
endmodule

// File: rtl/fdr_timer.sv
// Loadable down counter shared by the pulse and the gap phases.
module fdr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/fifo_dma_req_ctrl.sv
module fifo_dma_req_ctrl
    import fdr_pkg::*;
#(
    parameter int BURST_LEN   = 16,
    parameter int LVL_W       = 8,
    parameter int PW_W        = 4,
    parameter int GAP_CYC     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW_W-1:0] cfg_pulse_len,
    input  logic            dir_rd,
    input  logic            single_mode,
    input  logic [LVL_W-1:0] fifo_free,
    input  logic [LVL_W-1:0] fifo_used,
    input  logic            dma_ack,
    input  logic            wr_strobe,
    input  logic            rd_strobe,
    output logic            dreq,
    output logic            fifo_push,
    output logic            fifo_pop,
    output logic            svc_req
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam int TMR_W = (GAP_W > PW_W) ? GAP_W : PW_W;
    localparam logic [LVL_W-1:0] BURST_WORDS = LVL_W'(BURST_LEN);

    req_state_e state_q, state_d;
    logic       dir_q;
    logic [1:0] strb_prev_q;
    logic [2:0] sync_lvl;
    logic       ack_s, wr_rise, rd_rise;
    logic       active, acc_hit, burst_done, room_ok, start;
    logic       tmr_load, tmr_expire;
    logic [TMR_W-1:0] tmr_val;

    // Bit 2: acknowledge, bit 1: read strobe, bit 0: write strobe.
    fdr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dma_ack, rd_strobe, wr_strobe}),
        .sync_out (sync_lvl)
    );

    assign ack_s   = sync_lvl[2];
    assign wr_rise = sync_lvl[0] & ~strb_prev_q[0];
    assign rd_rise = sync_lvl[1] & ~strb_prev_q[1];

    assign active  = (state_q == REQ_PULSE) || (state_q == REQ_LEVEL)
                   || (state_q == REQ_XFER);
    assign acc_hit = active && ack_s && (dir_q ? rd_rise : wr_rise);
    assign room_ok = dir_rd ? (fifo_used >= BURST_WORDS)
                            : (fifo_free >= BURST_WORDS);
    assign start   = !single_mode && room_ok;

    fdr_burst_cnt #(.LEN(BURST_LEN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (acc_hit),
        .last_hit (burst_done)
    );

    fdr_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    // Next state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(GAP_CYC);
        unique case (state_q)
            REQ_IDLE: begin
                if (start) begin
                    if (cfg_pulse_len == '0) begin
                        state_d = REQ_LEVEL;
                    end else begin
                        state_d  = REQ_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(cfg_pulse_len);
                    end
                end
            end
            REQ_PULSE: begin
                if (burst_done) begin
                    state_d  = REQ_GAP;
                    tmr_load = 1'b1;
                end else if (tmr_expire) begin
                    state_d = REQ_XFER;
                end
            end
            REQ_LEVEL: begin
                if (burst_done) begin
                    state_d  = REQ_GAP;
                    tmr_load = 1'b1;
                end else if (acc_hit) begin
                    state_d = REQ_XFER;
                end
            end
            REQ_XFER: begin
                if (burst_done) begin
                    state_d  = REQ_GAP;
                    tmr_load = 1'b1;
                end
            end
            REQ_GAP: begin
                if (tmr_expire) begin
                    state_d = REQ_IDLE;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    // State register and registered side state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= REQ_IDLE;
            dir_q       <= 1'b0;
            strb_prev_q <= '0;
            svc_req     <= 1'b0;
        end else begin
            state_q     <= state_d;
            strb_prev_q <= sync_lvl[1:0];
            svc_req     <= single_mode && (fifo_used != '0);
            if (state_q == REQ_IDLE && start) begin
                dir_q <= dir_rd;
            end
        end
    end

    // Outputs
    always_comb begin
        dreq      = (state_q == REQ_PULSE) || (state_q == REQ_LEVEL);
        fifo_push = acc_hit && !dir_q;
        fifo_pop  = (acc_hit && dir_q)
                  || (single_mode && (state_q == REQ_IDLE) && rd_rise);
    end
endmodule

// File: rtl/fdr_checker.sv
module fdr_checker #(
    parameter int BURST_LEN = 16,
    parameter int LVL_W     = 8,
    parameter int PW_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PW_W-1:0]  cfg_pulse_len,
    input logic             dir_rd,
    input logic             single_mode,
    input logic [LVL_W-1:0] fifo_free,
    input logic [LVL_W-1:0] fifo_used,
    input logic             dreq,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             svc_req
);
    localparam logic [LVL_W-1:0] WORDS = LVL_W'(BURST_LEN);

    logic [5:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (dreq) begin
            run_len <= (run_len == 6'h3f) ? run_len : run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!dreq && !fifo_push && !fifo_pop && !svc_req))
        else $error("R1 outputs not idle after reset");

    a_r2_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && cfg_pulse_len != '0) |-> (run_len < 6'(cfg_pulse_len)))
        else $error("R2 request pulse too long");

    a_r4_room_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> $past(dir_rd ? (fifo_used >= WORDS) : (fifo_free >= WORDS)))
        else $error("R4 request without room");

    a_r5_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_pop))
        else $error("R5 push and pop together");

    a_r9_single_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && !dreq) |=> !dreq)
        else $error("R9 request in single mode");
endmodule

bind fifo_dma_req_ctrl fdr_checker #(
    .BURST_LEN (BURST_LEN),
    .LVL_W     (LVL_W),
    .PW_W      (PW_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pulse_len (cfg_pulse_len),
    .dir_rd        (dir_rd),
    .single_mode   (single_mode),
    .fifo_free     (fifo_free),
    .fifo_used     (fifo_used),
    .dreq          (dreq),
    .fifo_push     (fifo_push),
    .fifo_pop      (fifo_pop),
    .svc_req       (svc_req)
);

// File: tb/fifo_dma_req_ctrl_tb.sv
module fifo_dma_req_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int GAP   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg = 4'd0;
    logic       dir_rd = 1'b0;
    logic       single_mode = 1'b0;
    logic [7:0] free = 8'd0;
    logic [7:0] used = 8'd0;
    logic       dack = 1'b0;
    logic       wr_s = 1'b0;
    logic       rd_s = 1'b0;
    logic       dreq, fifo_push, fifo_pop, svc_req;

    int tests = 0;
    int fails = 0;
    int cyc = 0, n_push = 0, n_pop = 0, n_rise = 0;
    int last_acc_cyc = 0, last_rise_cyc = 0;
    logic dreq_d = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fifo_dma_req_ctrl #(.GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_pulse_len(cfg), .dir_rd(dir_rd),
        .single_mode(single_mode), .fifo_free(free), .fifo_used(used),
        .dma_ack(dack), .wr_strobe(wr_s), .rd_strobe(rd_s),
        .dreq(dreq), .fifo_push(fifo_push), .fifo_pop(fifo_pop), .svc_req(svc_req)
    );

    always @(negedge clk) begin
        cyc++;
        if (fifo_push) begin n_push++; last_acc_cyc = cyc; end
        if (fifo_pop)  begin n_pop++;  last_acc_cyc = cyc; end
        if (dreq && !dreq_d) begin n_rise++; last_rise_cyc = cyc; end
        dreq_d = dreq;
    end

    function automatic int exp_gap();
        return GAP + 2;
    endfunction

    function automatic bit exp_room(input bit rd, input int f, input int u);
        return rd ? (u >= 16) : (f >= 16);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act,
                           input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic access(input bit rd, input bit ack, input int hi, input int lo);
        if (!ack) begin dack = 1'b0; tick(3); end
        if (rd) rd_s = 1'b1; else wr_s = 1'b1;
        tick(hi);
        rd_s = 1'b0;
        wr_s = 1'b0;
        tick(lo);
        if (!ack) begin tick(2); dack = 1'b1; tick(3); end
    endtask

    task automatic measure_pulse(output int width);
        int t = 0;
        @(negedge clk);
        while (!dreq && t < 400) begin @(negedge clk); t++; end
        width = 0;
        while (dreq && width < 400) begin width++; @(negedge clk); end
        tick(1);
    endtask

    task automatic run_burst(input bit rd, input bit noise, input bit drain_last,
                             input int flip_at, input int n_acc);
        for (int i = 0; i < n_acc; i++) begin
            if (noise && ($urandom % 3 == 0)) begin
                access(rd, 1'b0, 2 + $urandom % 3, 2 + $urandom % 2);
                access(!rd, 1'b1, 2, 2);
            end
            if (i == flip_at) dir_rd = ~dir_rd;
            if (drain_last && i == n_acc - 1) begin free = 8'd0; used = 8'd0; end
            access(rd, 1'b1, 2 + $urandom % 3, 2 + $urandom % 3);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int w, p0, q0, r0, k, t;
        void'($urandom(32'h1234_5678));
        // R1: reset state
        tick(3);
        @(negedge clk);
        chk("R1", "dreq in reset", int'(dreq), 0);
        chk("R1", "push/pop/svc in reset", int'(fifo_push | fifo_pop | svc_req), 0);
        tick(1);
        rst_n = 1'b1;
        dack = 1'b1;
        // R4: no room, no request
        cfg = 4'd5;
        tick(20);
        chk("R4", "rises with free=0", n_rise, int'(exp_room(0, 0, 0)));
        used = 8'd40;
        tick(20);
        chk("R4", "rises write dir with only used", n_rise, int'(exp_room(0, 0, 40)));
        used = 8'd0;
        // R2/R5/R6/R7 write burst, pulse 5
        free = 8'd32;
        measure_pulse(w);
        chk("R2", "pulse width cfg=5", w, 5);
        p0 = n_push; q0 = n_pop; r0 = n_rise;
        access(1'b0, 1'b0, 3, 2);
        chk("R6", "push on unacked strobe", n_push - p0, 0);
        run_burst(1'b0, 1'b1, 1'b0, -1, 15);
        tick(4);
        chk("R5", "pushes after 15 accesses", n_push - p0, 15);
        chk("R5", "pops in write burst", n_pop - q0, 0);
        chk("R7", "re-request before 16th", n_rise - r0, 0);
        access(1'b0, 1'b1, 2, 2);
        t = 0;
        while (n_rise == r0 && t < 50) begin @(posedge clk); t++; end
        #1;
        chk("R5", "pushes after 16 accesses", n_push - p0, 16);
        chk("R7", "gap to next request", last_rise_cyc - last_acc_cyc, exp_gap());
        free = 8'd0;
        run_burst(1'b0, 1'b0, 1'b0, -1, 16);
        tick(6);
        r0 = n_rise;
        tick(20);
        chk("R4", "no request after drain to free=0", n_rise - r0, 0);
        // R8 read burst with mid-burst direction flip
        cfg = 4'd3; dir_rd = 1'b1; used = 8'd16;
        measure_pulse(w);
        chk("R2", "pulse width cfg=3", w, 3);
        p0 = n_push; q0 = n_pop;
        run_burst(1'b1, 1'b1, 1'b1, 5, 16);
        tick(6);
        chk("R8", "pops after dir flip", n_pop - q0, 16);
        chk("R8", "pushes after dir flip", n_push - p0, 0);
        // R3 level mode (dir_rd now 0)
        cfg = 4'd0; dir_rd = 1'b0; free = 8'd32;
        t = 0;
        @(negedge clk);
        while (!dreq && t < 50) begin @(negedge clk); t++; end
        tick(30);
        @(negedge clk);
        chk("R3", "level held without strobe", int'(dreq), 1);
        tick(1);
        p0 = n_push;
        access(1'b0, 1'b0, 3, 2);
        @(negedge clk);
        chk("R6", "level kept on unacked strobe", int'(dreq), 1);
        tick(1);
        wr_s = 1'b1;
        k = 0;
        repeat (6) begin @(negedge clk); if (dreq) k++; end
        tick(1);
        wr_s = 1'b0;
        tick(2);
        chk_rng("R3", "cycles to level drop", k, 2, 4);
        run_burst(1'b0, 1'b0, 1'b1, -1, 15);
        tick(6);
        chk("R3", "pushes in level burst", n_push - p0, 16);
        // R9 single mode
        single_mode = 1'b1;
        tick(2);
        @(negedge clk);
        chk("R9", "svc_req empty", int'(svc_req), 0);
        tick(1);
        used = 8'd5;
        tick(1);
        @(negedge clk);
        chk("R9", "svc_req not empty", int'(svc_req), 1);
        tick(1);
        used = 8'd40; free = 8'd40;
        r0 = n_rise; q0 = n_pop;
        tick(20);
        chk("R9", "request in single mode", n_rise - r0, 0);
        for (int i = 0; i < 3; i++) access(1'b1, 1'b1, 2, 2);
        tick(4);
        chk("R9", "single-mode pops", n_pop - q0, 3);
        used = 8'd0; free = 8'd0;
        tick(2);
        @(negedge clk);
        chk("R9", "svc_req after empty", int'(svc_req), 0);
        tick(1);
        single_mode = 1'b0;
        tick(4);
        // Random bursts
        for (int it = 0; it < 8; it++) begin
            int c;
            bit d;
            c = 1 + ($urandom % 15);
            d = 1'($urandom % 2);
            cfg = 4'(c); dir_rd = d;
            tick(1);
            free = 8'd32; used = 8'd32;
            measure_pulse(w);
            chk("R2", "random pulse width", w, c);
            p0 = n_push; q0 = n_pop;
            run_burst(d, 1'b1, 1'b1, -1, 16);
            tick(8);
            chk("R5", "random burst own-dir count", d ? n_pop - q0 : n_push - p0, 16);
            chk("R5", "random burst other-dir count", d ? n_push - p0 : n_pop - q0, 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule